// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Nibble Half-Carry

This block is the arithmetic and logic core of a small 8-bit processor datapath. Each clock it takes an accumulator value, a second operand, a 4-bit operation select and the current condition flags. On the next clock edge it presents the new accumulator value and the updated flags. The flags are zero (Z), subtract (N), half-carry (H) and carry (C). The surrounding datapath picks the operand and decides whether to write the result back. This block only computes.

Besides the usual add, subtract and bitwise operations, the unit keeps a half-carry flag. That flag records the carry or borrow across the boundary between the low and high nibble. Together with the subtract flag, it drives a decimal-adjust operation that corrects the accumulator after a packed-BCD add or subtract. Every operation has its own rule for which flags it writes and which it leaves alone. Getting those rules right is most of the block's job.

Top module: `acu_alu_core`

## Requirements
- R1: Outputs are registered. `result_o` and `flags_o` show the operation whose inputs were present at the previous rising clock edge. While `rst_n` is low, both outputs are 0. The flag bus is packed as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C, on both `flags_i` and `flags_o`. The `op_i` codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 decimal adjust, 11 complement, 12 set-carry, 13 complement-carry, 14 and 15 reserved.
- R2: Add (0) and add-with-carry (1) produce the 8-bit sum of accumulator and operand, with carry-in C for op 1 only. They clear N. H is set when the low-nibble sum plus carry-in reaches 0x10. C is set when the full sum reaches 0x100. Z is set when the 8-bit result is zero.
- R3: Subtract (2) and subtract-with-borrow (3) produce the accumulator minus the operand, with borrow-in C for op 3 only. They set N. H is set on a borrow out of the low nibble, borrow-in included. C is set when the full difference is negative. Z is taken from the 8-bit result.
- R4: Compare (7) sets the four flags exactly as subtract does, but the result equals the unmodified accumulator.
- R5: AND (4), XOR (5) and OR (6) clear N and C. AND sets H, while XOR and OR clear it. All three set Z when the result is zero.
- R6: Increment (8) and decrement (9) apply to the accumulator and wrap modulo 256. Increment clears N and sets H when the old low nibble was 0xF. Decrement sets N and sets H when the old low nibble was 0x0. Both set Z from the result and keep C unchanged.
- R7: Decimal adjust (10) with incoming N=1 adds 0xFA when H is set and 0xA0 when C is set, modulo 256. C and N are left unchanged.
- R8: Decimal adjust with incoming N=0 first adds 0x06 when the low nibble exceeds 9 or H is set. If the intermediate value masked with 0x1F0 exceeds 0x90, or C is set, it then adds 0x60 and sets C. Otherwise it clears C. N is left unchanged.
- R9: Decimal adjust always clears H and sets Z from its 8-bit result.
- R10: Complement (11) inverts the accumulator and sets H and N. Z and C are kept.
- R11: Set-carry (12) sets C and complement-carry (13) inverts C. Both clear H and N, keep Z, and leave the result equal to the accumulator.
- R12: The reserved codes 14 and 15 return the accumulator unchanged and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select, encoding in R1 |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| result_o | output | 8 | Registered result |
| flags_o | output | 4 | Registered flags {Z,N,H,C} |

## Verification
The bench aims at the nibble boundary. It drives adds whose low nibbles sum to exactly 0x10, and subtracts where only the borrow-in pushes the low nibble negative. A design that drops the carry-in from the half-carry term, or that inverts the borrow sense, reports a wrong H there. Decimal adjust is driven with both N settings and with H and C set together. It is also driven with 0x9A, which must wrap to zero and set C; a design that tests the intermediate value before the low correction, or that clears C after a subtract, misses that case. A long pseudo-random sweep also covers every code against an independent model. That sweep catches operations that change a flag they must keep, such as C on increment, or that write the compare result into the accumulator.

// File: rtl/acu_pkg.sv
package acu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_AND  = 4'd4,
      OP_XOR  = 4'd5,
      OP_OR   = 4'd6,
      OP_CMP  = 4'd7,
      OP_INC  = 4'd8,
      OP_DEC  = 4'd9,
      OP_DAA  = 4'd10,
      OP_CPL  = 4'd11,
      OP_SCF  = 4'd12,
      OP_CCF  = 4'd13,
      OP_RSV0 = 4'd14,
      OP_RSV1 = 4'd15
   } acu_op_e;

   // packed so that bit 3 = Z, 2 = N, 1 = H, 0 = C
   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } acu_flags_t;

endpackage

// File: rtl/acu_nibble_adder.sv
// Nibble-chained adder/subtractor; the carry out of the first nibble is the half flag.
module acu_nibble_adder #(
   parameter int DATA_W   = 8,
   parameter int NIBBLE_W = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              half_o,
   output logic              carry_o
);
   localparam int NIBBLES = DATA_W / NIBBLE_W;

   logic [NIBBLES:0]  cy;
   logic [DATA_W-1:0] b_eff;

   // subtraction as a + ~b + ~borrow; carries then mean "no borrow"
   assign b_eff = sub_i ? ~b_i : b_i;
   assign cy[0] = sub_i ? ~cin_i : cin_i;

   genvar g;
   generate
      for (g = 0; g < NIBBLES; g++) begin : g_nib
         logic [NIBBLE_W:0] part;
         assign part = {1'b0, a_i[g*NIBBLE_W +: NIBBLE_W]}
                     + {1'b0, b_eff[g*NIBBLE_W +: NIBBLE_W]}
                     + {{NIBBLE_W{1'b0}}, cy[g]};
         assign sum_o[g*NIBBLE_W +: NIBBLE_W] = part[NIBBLE_W-1:0];
         assign cy[g+1] = part[NIBBLE_W];
      end
   endgenerate

   assign half_o  = sub_i ? ~cy[1]       : cy[1];
   assign carry_o = sub_i ? ~cy[NIBBLES] : cy[NIBBLES];
endmodule

// File: rtl/acu_logic_unit.sv
module acu_logic_unit
   import acu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  acu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_XOR:  res_o = a_i ^ b_i;
         OP_OR:   res_o = a_i | b_i;
         default: res_o = a_i & b_i;
      endcase
   end
endmodule

// File: rtl/acu_decimal_adjust.sv
// Packed-BCD correction of the accumulator, steered by the incoming N, H and C.
module acu_decimal_adjust #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              n_i,
   input  logic              h_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o
);
   localparam int WIDE_W = DATA_W + 2;
   localparam logic [DATA_W-1:0] SUB_LO_FIX = 8'hFA;
   localparam logic [DATA_W-1:0] SUB_HI_FIX = 8'hA0;
   localparam logic [WIDE_W-1:0] ADD_LO_FIX = 10'h006;
   localparam logic [WIDE_W-1:0] ADD_HI_FIX = 10'h060;
   localparam logic [WIDE_W-1:0] HI_MASK    = 10'h1F0;
   localparam logic [WIDE_W-1:0] HI_LIMIT   = 10'h090;

   logic [WIDE_W-1:0] step_lo;
   logic [WIDE_W-1:0] step_hi;
   logic              lo_fix;
   logic              hi_fix;

   always_comb begin
      lo_fix  = (a_i[3:0] > 4'd9) || h_i;
      step_lo = {2'b00, a_i} + (lo_fix ? ADD_LO_FIX : '0);
      hi_fix  = ((step_lo & HI_MASK) > HI_LIMIT) || c_i;
      step_hi = step_lo + (hi_fix ? ADD_HI_FIX : '0);
      if (n_i) begin
         res_o = a_i + (h_i ? SUB_LO_FIX : '0) + (c_i ? SUB_HI_FIX : '0);
         c_o   = c_i;
      end else begin
         res_o = step_hi[DATA_W-1:0];
         c_o   = hi_fix;
      end
   end
endmodule

// File: rtl/acu_alu_core.sv
module acu_alu_core
   import acu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NIBBLE_W = 4,
   parameter int FLAG_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DATA_W-1:0] result_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("acu_alu_core: decimal adjust constants need DATA_W == 8");
      end
      if (NIBBLE_W * 2 != DATA_W) begin : g_bad_nibble
         $error("acu_alu_core: DATA_W must hold exactly two nibbles");
      end
      if (FLAG_W != $bits(acu_flags_t)) begin : g_bad_flags
         $error("acu_alu_core: FLAG_W must match the flag record");
      end
   endgenerate

   acu_op_e           op;
   acu_flags_t        fin;
   acu_flags_t        nxt_f;
   logic [DATA_W-1:0] nxt_res;

   logic              add_sub;
   logic              add_cin;
   logic [DATA_W-1:0] add_b;
   logic [DATA_W-1:0] add_sum;
   logic              add_half;
   logic              add_carry;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] daa_res;
   logic              daa_c;

   always_comb begin
      op      = acu_op_e'(op_i);
      fin     = acu_flags_t'(flags_i);
      add_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
      add_b   = ((op == OP_INC) || (op == OP_DEC)) ? ONE : opnd_i;
      add_cin = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
   end

   acu_nibble_adder #(
      .DATA_W   (DATA_W),
      .NIBBLE_W (NIBBLE_W)
   ) u_adder (
      .a_i     (acc_i),
      .b_i     (add_b),
      .cin_i   (add_cin),
      .sub_i   (add_sub),
      .sum_o   (add_sum),
      .half_o  (add_half),
      .carry_o (add_carry)
   );

   acu_logic_unit #(
      .DATA_W (DATA_W)
   ) u_logic (
      .op_i  (op),
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .res_o (logic_res)
   );

   acu_decimal_adjust #(
      .DATA_W (DATA_W)
   ) u_daa (
      .a_i   (acc_i),
      .n_i   (fin.n),
      .h_i   (fin.h),
      .c_i   (fin.c),
      .res_o (daa_res),
      .c_o   (daa_c)
   );

   always_comb begin
      nxt_res = acc_i;
      nxt_f   = fin;
      unique case (op)
         OP_ADD, OP_ADC: begin
            nxt_res = add_sum;
            nxt_f.z = ~|add_sum;
            nxt_f.n = 1'b0;
            nxt_f.h = add_half;
            nxt_f.c = add_carry;
         end
         OP_SUB, OP_SBC, OP_CMP: begin
            nxt_res = (op == OP_CMP) ? acc_i : add_sum;
            nxt_f.z = ~|add_sum;
            nxt_f.n = 1'b1;
            nxt_f.h = add_half;
            nxt_f.c = add_carry;
         end
         OP_AND, OP_XOR, OP_OR: begin
            nxt_res = logic_res;
            nxt_f.z = ~|logic_res;
            nxt_f.n = 1'b0;
            nxt_f.h = (op == OP_AND);
            nxt_f.c = 1'b0;
         end
         OP_INC, OP_DEC: begin
            nxt_res = add_sum;
            nxt_f.z = ~|add_sum;
            nxt_f.n = (op == OP_DEC);
            nxt_f.h = add_half;
         end
         OP_DAA: begin
            nxt_res = daa_res;
            nxt_f.z = ~|daa_res;
            nxt_f.h = 1'b0;
            nxt_f.c = daa_c;
         end
         OP_CPL: begin
            nxt_res = ~acc_i;
            nxt_f.n = 1'b1;
            nxt_f.h = 1'b1;
         end
         OP_SCF, OP_CCF: begin
            nxt_f.n = 1'b0;
            nxt_f.h = 1'b0;
            nxt_f.c = (op == OP_SCF) ? 1'b1 : ~fin.c;
         end
         default: begin
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         flags_o  <= '0;
      end else begin
         result_o <= nxt_res;
         flags_o  <= nxt_f;
      end
   end
endmodule

// File: rtl/acu_alu_chk.sv
module acu_alu_chk
   import acu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FLAG_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [FLAG_W-1:0] flags_i,
   input logic [DATA_W-1:0] result_o,
   input logic [FLAG_W-1:0] flags_o
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R3
   sub_sets_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(op_i) == OP_SUB || $past(op_i) == OP_SBC ||
                 $past(op_i) == OP_CMP || $past(op_i) == OP_DEC))
      |-> flags_o[2]);

   // R4
   cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == OP_CMP) |-> (result_o == $past(acc_i)));

   // R5
   logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(op_i) == OP_AND || $past(op_i) == OP_XOR || $past(op_i) == OP_OR))
      |-> (!flags_o[2] && !flags_o[0] && flags_o[1] == ($past(op_i) == OP_AND)
           && flags_o[3] == (result_o == '0)));

   // R6
   incdec_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
      |-> (flags_o[0] == $past(flags_i[0])));

   // R9
   daa_h_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == OP_DAA)
      |-> (!flags_o[1] && flags_o[3] == (result_o == '0) && flags_o[2] == $past(flags_i[2])));

   // R10
   cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == OP_CPL)
      |-> (result_o == ~$past(acc_i) && flags_o[2:1] == 2'b11));

   // R11
   carry_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(op_i) == OP_SCF || $past(op_i) == OP_CCF))
      |-> (flags_o[2:1] == 2'b00 && result_o == $past(acc_i)
           && flags_o[0] == (($past(op_i) == OP_SCF) ? 1'b1 : !$past(flags_i[0]))));

   // R12
   reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ($past(op_i) == OP_RSV0 || $past(op_i) == OP_RSV1))
      |-> (result_o == $past(acc_i) && flags_o == $past(flags_i)));

   logic unused_ok;
   assign unused_ok = ^opnd_i;
endmodule

bind acu_alu_core acu_alu_chk u_chk (.*);

// File: tb/tb_acu_alu_core.sv
module tb_acu_alu_core;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = 4'd0;
   logic [7:0] acc_i = 8'd0;
   logic [7:0] opnd_i = 8'd0;
   logic [3:0] flags_i = 4'd0;
   logic [7:0] result_o;
   logic [3:0] flags_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] res;
      logic [3:0] flg;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   acu_alu_core dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op_i),
      .acc_i    (acc_i),
      .opnd_i   (opnd_i),
      .flags_i  (flags_i),
      .result_o (result_o),
      .flags_o  (flags_o)
   );

   // reference written from the requirement list; returns {result, Z, N, H, C}
   function automatic logic [11:0] model(input int op, input int a, input int b, input logic [3:0] f);
      int r, d, t, ci;
      logic z, n, h, c;
      z = f[3]; n = f[2]; h = f[1]; c = f[0];
      r = a;
      case (op)
         0, 1: begin
            ci = (op == 1) ? int'(c) : 0;
            t  = a + b + ci;
            h  = ((a & 15) + (b & 15) + ci) >= 16;
            c  = t >= 256;
            n  = 1'b0;
            r  = t & 255;
            z  = (r == 0);
         end
         2, 3, 7: begin
            ci = (op == 3) ? int'(c) : 0;
            d  = a - b - ci;
            h  = ((a & 15) - (b & 15) - ci) < 0;
            c  = d < 0;
            n  = 1'b1;
            z  = ((d & 255) == 0);
            r  = (op == 7) ? a : (d & 255);
         end
         4, 5, 6: begin
            r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
            z = (r == 0); n = 1'b0; h = (op == 4); c = 1'b0;
         end
         8: begin
            r = (a + 1) & 255; h = (a & 15) == 15; n = 1'b0; z = (r == 0);
         end
         9: begin
            r = (a - 1) & 255; h = (a & 15) == 0; n = 1'b1; z = (r == 0);
         end
         10: begin
            if (n) begin
               t = a;
               if (h) t = t + 'hFA;
               if (c) t = t + 'hA0;
               r = t & 255;
            end else begin
               t = a;
               if ((a & 15) > 9 || h) t = t + 6;
               if ((t & 'h1F0) > 'h90 || c) begin
                  t = t + 'h60; c = 1'b1;
               end else begin
                  c = 1'b0;
               end
               r = t & 255;
            end
            h = 1'b0;
            z = (r == 0);
         end
         11: begin
            r = (~a) & 255; h = 1'b1; n = 1'b1;
         end
         12: begin
            c = 1'b1; h = 1'b0; n = 1'b0;
         end
         13: begin
            c = !c; h = 1'b0; n = 1'b0;
         end
         default: r = a;
      endcase
      return {r[7:0], z, n, h, c};
   endfunction

   function automatic string req_of(input int op);
      case (op)
         0, 1:    return "R2";
         2, 3:    return "R3";
         4, 5, 6: return "R5";
         7:       return "R4";
         8, 9:    return "R6";
         10:      return "R8";
         11:      return "R10";
         12, 13:  return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] r, input logic [3:0] f,
                        input logic [7:0] er, input logic [3:0] ef);
      checks++;
      if (r !== er || f !== ef) begin
         errors++;
         $display("FAIL %s: result=%02h flags=%04b expected result=%02h flags=%04b",
                  tag, r, f, er, ef);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] f, input string tag);
      exp_t e;
      logic [11:0] m;
      @(negedge clk);
      op_i = op; acc_i = a; opnd_i = b; flags_i = f;
      m = model(int'(op), int'(a), int'(b), f);
      e.res = m[11:4];
      e.flg = m[3:0];
      e.tag = tag;
      sb.push_back(e);
   endtask

   // scoreboard monitor: each item is due just after the edge that registers it
   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, result_o, flags_o, e.res, e.flg);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: result=%02h flags=%04b expected completion", result_o, flags_o);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      // R1: inputs busy during reset, outputs must stay cleared
      op_i = 4'd0; acc_i = 8'h7F; opnd_i = 8'h01; flags_i = 4'hF;
      repeat (3) @(negedge clk);
      check("R1", result_o, flags_o, 8'h00, 4'h0);
      rst_n = 1'b1;

      // R2
      drive(4'd0, 8'h3A, 8'hC6, 4'h0, "R2");
      drive(4'd0, 8'h0F, 8'h01, 4'h1, "R2");
      drive(4'd1, 8'hE1, 8'h0F, 4'h1, "R2");
      drive(4'd1, 8'hFF, 8'h00, 4'h1, "R2");
      // R3
      drive(4'd2, 8'h3E, 8'h3E, 4'h0, "R3");
      drive(4'd2, 8'h3E, 8'h0F, 4'h0, "R3");
      drive(4'd2, 8'h10, 8'h20, 4'h0, "R3");
      drive(4'd3, 8'h3B, 8'h2A, 4'h1, "R3");
      drive(4'd3, 8'h30, 8'h20, 4'h1, "R3");
      // R4
      drive(4'd7, 8'h3C, 8'h40, 4'h0, "R4");
      drive(4'd7, 8'h55, 8'h55, 4'h0, "R4");
      // R5
      drive(4'd4, 8'h5A, 8'h3F, 4'h5, "R5");
      drive(4'd5, 8'h5A, 8'h5A, 4'h7, "R5");
      drive(4'd6, 8'h00, 8'h00, 4'h3, "R5");
      // R6
      drive(4'd8, 8'hFF, 8'h00, 4'h1, "R6");
      drive(4'd8, 8'h0F, 8'h00, 4'h0, "R6");
      drive(4'd9, 8'h01, 8'h00, 4'h1, "R6");
      drive(4'd9, 8'h10, 8'h00, 4'h0, "R6");
      drive(4'd9, 8'h00, 8'h00, 4'h0, "R6");
      // R7
      drive(4'd10, 8'h83, 8'h00, 4'b0110, "R7");
      drive(4'd10, 8'h33, 8'h00, 4'b0111, "R7");
      drive(4'd10, 8'h06, 8'h00, 4'b0100, "R7");
      // R8 and R9
      drive(4'd10, 8'h7D, 8'h00, 4'b0000, "R8");
      drive(4'd10, 8'h9A, 8'h00, 4'b0000, "R9");
      drive(4'd10, 8'h02, 8'h00, 4'b0011, "R8");
      drive(4'd10, 8'h99, 8'h00, 4'b1010, "R9");
      // R10
      drive(4'd11, 8'h35, 8'h00, 4'b1001, "R10");
      // R11
      drive(4'd12, 8'h44, 8'h00, 4'b1110, "R11");
      drive(4'd13, 8'h44, 8'h00, 4'b0111, "R11");
      drive(4'd13, 8'h44, 8'h00, 4'b1000, "R11");
      // R12
      drive(4'd14, 8'hA5, 8'h12, 4'b1011, "R12");
      drive(4'd15, 8'h5A, 8'h34, 4'b0100, "R12");

      // sweep across all codes against the model
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 800; i++) begin
         lf = lf ^ (lf << 13);
         lf = lf ^ (lf >> 17);
         lf = lf ^ (lf << 5);
         drive(4'(i % 16), lf[7:0], lf[15:8], lf[19:16], req_of(i % 16));
      end

      @(negedge clk);
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule